// File: doc/BRIEF.md
# Processor Cell Insertion Port

This block lets a host processor place one fixed-size cell into a cell stream that runs in two directions, downstream and upstream. The host first writes the cell words into a small transmit buffer through a plain register write port. It then writes a command register in which one bit asks for downstream insertion and another asks for upstream insertion.

The block watches the slot-grant input of the chosen direction. On the first idle cycle in which that grant is high while a request is pending, it sends the buffered cell one word per beat on a valid/ready output. Each beat carries start-of-cell and end-of-cell markers and a direction flag. When the last word has been accepted, the block clears the pending request so the host can see that the insertion is finished.

Back-pressure rules on the output stream: a beat transfers only on a cycle in which `cell_valid` and `cell_ready` are both high. While `cell_valid` is high and `cell_ready` is low, the block holds the word, the markers and the direction unchanged. Once a cell has started, `cell_valid` stays high until the last word transfers. The slot grants matter only when the block is idle, so they do not need to stay high during the cell.

Top module: `cell_inject_port`

## Requirements
- R1: A host write to address `PAYLOAD_BASE + i` (i from 0 to NUM_WORDS-1, default base 0x80 giving 0x80 to 0x9A) stores the data as word i. Word i is the (i+1)-th word sent in the next cell.
- R2: Writing the command register (address `CMD_ADDR`, default 0x7F) with data bit 0 set and bit 1 clear requests a downstream cell, which is sent with `cell_dir` = 0. The up slot grant has no effect on this request.
- R3: Writing the command register with data bit 1 set requests an upstream cell, which is sent with `cell_dir` = 1. `req_pending` shows the written bits 1:0 until the cell ends.
- R4: When both request bits are set, the block behaves as for an upstream-only request: the down slot grant is ignored, and the cell is sent upstream.
- R5: The cell starts on the first idle clock edge at which a request is pending and the selected direction's slot grant is high. `cell_valid` is high, with `cell_sop` set, in the following cycle. While the selected grant stays low, `cell_valid` stays low.
- R6: A cell is exactly NUM_WORDS beats, sent in word-index order. `cell_sop` is set only on word 0 and `cell_eop` only on the last word.
- R7: While `cell_valid` is high and `cell_ready` is low, `cell_valid`, `cell_data`, `cell_sop`, `cell_eop` and `cell_dir` hold their values.
- R8: In the cycle after the last word transfers, `req_pending` reads 0 and `cell_valid` is low. Both request bits clear, including when both were set.
- R9: While a cell is being sent, host writes to the payload words and to the command register have no effect.
- R10: After reset, `req_pending` is 0, `cell_valid` is low, and all payload words are 0.
- R11: Host writes to addresses outside the payload window and other than `CMD_ADDR` change neither the payload nor `req_pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_addr | input | ADDR_W | Host write address |
| host_wr_data | input | WORD_W | Host write data |
| req_pending | output | 2 | Pending request bits (bit 0 downstream, bit 1 upstream) |
| dn_slot | input | 1 | Downstream slot grant |
| up_slot | input | 1 | Upstream slot grant |
| cell_ready | input | 1 | Sink ready for the cell stream |
| cell_valid | output | 1 | Cell word valid |
| cell_data | output | WORD_W | Cell word |
| cell_sop | output | 1 | First word of the cell |
| cell_eop | output | 1 | Last word of the cell |
| cell_dir | output | 1 | Direction of the cell (0 downstream, 1 upstream) |

## Verification
The bench uses the default parameters: 16-bit words, a 27-word cell, the payload window at 0x80 and the command register at 0x7F. With these values it sends full-length cells, so the end-of-cell marker and the clearing of the request come from the real last index. Random 16-bit words show any mix-up in word order. Random `cell_ready` patterns stall the stream at the first word, in the middle and at the last word. Writes to 0x7E and 0x9B fall just outside the payload window, and writes at 0x80 and 0x9A land on its two edges.

// File: rtl/cip_pkg.sv
package cip_pkg;
  typedef enum logic {
    DIR_DN = 1'b0,
    DIR_UP = 1'b1
  } cell_dir_e;

  localparam int REQ_DN_BIT = 0;
  localparam int REQ_UP_BIT = 1;
endpackage

// File: rtl/cip_payload_regs.sv
module cip_payload_regs #(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 27,
  parameter int IDX_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              lock,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] words [NUM_WORDS];

  for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        words[gi] <= '0;
      end else if (wr_en && !lock && (wr_idx == IDX_W'(gi))) begin
        words[gi] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_WORDS; k++) begin
      if (rd_idx == IDX_W'(k)) rd_data = words[k];
    end
  end
endmodule

// File: rtl/cip_dir_arb.sv
module cip_dir_arb
  import cip_pkg::*;
(
  input  logic [1:0] req,
  input  logic       dn_slot,
  input  logic       up_slot,
  output logic       go,
  output cell_dir_e  go_dir
);
  always_comb begin
    if (req[REQ_UP_BIT]) begin
      go     = up_slot;
      go_dir = DIR_UP;
    end else begin
      go     = req[REQ_DN_BIT] & dn_slot;
      go_dir = DIR_DN;
    end
  end
endmodule

// File: rtl/cip_tx_seq.sv
module cip_tx_seq
  import cip_pkg::*;
#(
  parameter int NUM_WORDS = 27,
  parameter int IDX_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  cell_dir_e        go_dir,
  input  logic             ready,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             sop,
  output logic             eop,
  output cell_dir_e        dir,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      dir  <= DIR_DN;
    end else if (!busy) begin
      if (go) begin
        busy <= 1'b1;
        idx  <= '0;
        dir  <= go_dir;
      end
    end else if (ready) begin
      if (idx == LAST_IDX) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign sop  = busy && (idx == '0);
  assign eop  = busy && (idx == LAST_IDX);
  assign done = busy && ready && (idx == LAST_IDX);
endmodule

// File: rtl/cell_inject_port.sv
module cell_inject_port
  import cip_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int NUM_WORDS    = 27,
  parameter int ADDR_W       = 8,
  parameter int PAYLOAD_BASE = 'h80,
  parameter int CMD_ADDR     = 'h7F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [ADDR_W-1:0] host_wr_addr,
  input  logic [WORD_W-1:0] host_wr_data,
  output logic [1:0]        req_pending,
  input  logic              dn_slot,
  input  logic              up_slot,
  input  logic              cell_ready,
  output logic              cell_valid,
  output logic [WORD_W-1:0] cell_data,
  output logic              cell_sop,
  output logic              cell_eop,
  output logic              cell_dir
);
  localparam int IDX_W = $clog2(NUM_WORDS);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(PAYLOAD_BASE);
  localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_ADDR);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(NUM_WORDS);

  logic [ADDR_W-1:0] wr_offset;
  logic              pay_hit;
  logic              cmd_hit;
  logic [IDX_W-1:0]  wr_idx;
  logic [1:0]        req_q;
  logic              go;
  cell_dir_e         go_dir;
  logic              busy;
  logic [IDX_W-1:0]  rd_idx;
  logic              seq_sop;
  logic              seq_eop;
  cell_dir_e         seq_dir;
  logic              done;
  logic [WORD_W-1:0] rd_word;

  // Address decode for the payload window and the command register
  assign wr_offset = host_wr_addr - BASE_A;
  assign pay_hit   = host_wr_en && (host_wr_addr >= BASE_A) && (wr_offset < SPAN_A);
  assign cmd_hit   = host_wr_en && (host_wr_addr == CMD_A);
  assign wr_idx    = wr_offset[IDX_W-1:0];

  // Command register: written only while idle, cleared by hardware on cell end
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 2'b00;
    end else if (done) begin
      req_q <= 2'b00;
    end else if (cmd_hit && !busy) begin
      req_q <= host_wr_data[1:0];
    end
  end

  cip_payload_regs #(
    .WORD_W   (WORD_W),
    .NUM_WORDS(NUM_WORDS),
    .IDX_W    (IDX_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (pay_hit),
    .wr_idx (wr_idx),
    .wr_data(host_wr_data),
    .lock   (busy),
    .rd_idx (rd_idx),
    .rd_data(rd_word)
  );

  cip_dir_arb u_arb (
    .req    (req_q),
    .dn_slot(dn_slot),
    .up_slot(up_slot),
    .go     (go),
    .go_dir (go_dir)
  );

  cip_tx_seq #(
    .NUM_WORDS(NUM_WORDS),
    .IDX_W    (IDX_W)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (go),
    .go_dir(go_dir),
    .ready (cell_ready),
    .busy  (busy),
    .idx   (rd_idx),
    .sop   (seq_sop),
    .eop   (seq_eop),
    .dir   (seq_dir),
    .done  (done)
  );

  assign req_pending = req_q;
  assign cell_valid  = busy;
  assign cell_data   = busy ? rd_word : '0;
  assign cell_sop    = seq_sop;
  assign cell_eop    = seq_eop;
  assign cell_dir    = (seq_dir == DIR_UP);
endmodule

// File: rtl/cell_inject_port_checker.sv
module cell_inject_port_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        req_pending,
  input logic              dn_slot,
  input logic              up_slot,
  input logic              cell_ready,
  input logic              cell_valid,
  input logic [WORD_W-1:0] cell_data,
  input logic              cell_sop,
  input logic              cell_eop,
  input logic              cell_dir
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_valid && !cell_ready) |=> (cell_valid && $stable(cell_data) &&
      $stable(cell_sop) && $stable(cell_eop) && $stable(cell_dir)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_valid && cell_ready && cell_eop) |=> (req_pending == 2'b00 && !cell_valid));

  p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cell_valid && ((req_pending[1] && up_slot) || (req_pending == 2'b01 && dn_slot)))
      |=> (cell_valid && cell_sop));

  p_up_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cell_valid && req_pending[1]) |=> (!cell_valid || cell_dir));

  p_no_down_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cell_valid && req_pending[1] && !up_slot) |=> !cell_valid);

  p_req_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_valid && !(cell_ready && cell_eop)) |=> $stable(req_pending));

  p_sop_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_valid && cell_ready && cell_sop) |=> !cell_sop);
endmodule

bind cell_inject_port cell_inject_port_checker #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_pending(req_pending),
  .dn_slot    (dn_slot),
  .up_slot    (up_slot),
  .cell_ready (cell_ready),
  .cell_valid (cell_valid),
  .cell_data  (cell_data),
  .cell_sop   (cell_sop),
  .cell_eop   (cell_eop),
  .cell_dir   (cell_dir)
);

// File: tb/cell_inject_port_tb.sv
module cell_inject_port_tb;
  localparam int WORD_W = 16;
  localparam int NW     = 27;
  localparam int ADDR_W = 8;
  localparam int BASE   = 'h80;
  localparam int CMDA   = 'h7F;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              host_wr_en = 1'b0;
  logic [ADDR_W-1:0] host_wr_addr = '0;
  logic [WORD_W-1:0] host_wr_data = '0;
  logic [1:0]        req_pending;
  logic              dn_slot = 1'b0;
  logic              up_slot = 1'b0;
  logic              cell_ready = 1'b0;
  logic              cell_valid;
  logic [WORD_W-1:0] cell_data;
  logic              cell_sop;
  logic              cell_eop;
  logic              cell_dir;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [WORD_W-1:0] exp_buf [NW];

  cell_inject_port #(
    .WORD_W(WORD_W), .NUM_WORDS(NW), .ADDR_W(ADDR_W),
    .PAYLOAD_BASE(BASE), .CMD_ADDR(CMDA)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr),
    .host_wr_data(host_wr_data), .req_pending(req_pending), .dn_slot(dn_slot),
    .up_slot(up_slot), .cell_ready(cell_ready), .cell_valid(cell_valid),
    .cell_data(cell_data), .cell_sop(cell_sop), .cell_eop(cell_eop), .cell_dir(cell_dir)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Expected direction for a command value: bit 1 wins when set
  function automatic bit exp_dir(input logic [1:0] cmd);
    return cmd[1];
  endfunction

  function automatic bit is_payload(input int a);
    return (a >= BASE) && (a < BASE + NW);
  endfunction

  task automatic host_write(input int addr, input logic [WORD_W-1:0] data);
    @(negedge clk);
    host_wr_en   = 1'b1;
    host_wr_addr = ADDR_W'(addr);
    host_wr_data = data;
    @(negedge clk);
    host_wr_en = 1'b0;
    if (is_payload(addr)) exp_buf[addr - BASE] = data;
  endtask

  // Send one cell: cmd request, grant timing, random ready, optional meddling writes
  task automatic run_cell(input logic [1:0] cmd, input bit meddle);
    bit want_up;
    int k;
    int guard;
    bit stalled;
    logic [WORD_W-1:0] pd;
    logic ps, pe, pdir;
    want_up = exp_dir(cmd);
    host_write(CMDA, WORD_W'(cmd));
    chk(req_pending == cmd, want_up ? "R3 req shown" : "R2 req shown", req_pending, cmd);
    // Offer only the wrong direction's grant: no start expected (R5, R4, R2)
    dn_slot = want_up;
    up_slot = !want_up;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!cell_valid, want_up ? "R4 wrong grant ignored" : "R2 wrong grant ignored", cell_valid, 0);
    end
    @(negedge clk);
    dn_slot = !want_up;
    up_slot = want_up;
    @(negedge clk);
    dn_slot = 1'b0;
    up_slot = 1'b0;
    chk(cell_valid && cell_sop, "R5 start cycle", {cell_valid, cell_sop}, 2'b11);
    k = 0;
    guard = 0;
    stalled = 1'b0;
    pd = '0; ps = 1'b0; pe = 1'b0; pdir = 1'b0;
    while (k < NW && guard < 2000) begin
      guard++;
      if (stalled)
        chk(cell_valid && cell_data == pd && cell_sop == ps && cell_eop == pe && cell_dir == pdir,
            "R7 hold under stall", cell_data, pd);
      cell_ready = ($urandom_range(0, 2) != 0);
      if (meddle && ($urandom_range(0, 1) == 1)) begin
        host_wr_en   = 1'b1;
        host_wr_addr = ($urandom_range(0, 3) == 0) ? ADDR_W'(CMDA)
                                                    : ADDR_W'(BASE + $urandom_range(0, NW - 1));
        host_wr_data = WORD_W'($urandom);
      end else begin
        host_wr_en = 1'b0;
      end
      #1;
      if (cell_valid && cell_ready) begin
        chk(cell_data == exp_buf[k], meddle ? "R9 payload locked" : "R1 word content", cell_data, exp_buf[k]);
        chk(cell_sop == (k == 0) && cell_eop == (k == NW - 1), "R6 markers",
            {cell_sop, cell_eop}, {k == 0, k == NW - 1});
        chk(cell_dir == want_up, want_up ? "R3 dir up" : "R2 dir down", cell_dir, want_up);
        k++;
        stalled = 1'b0;
      end else begin
        stalled = cell_valid;
        pd = cell_data; ps = cell_sop; pe = cell_eop; pdir = cell_dir;
      end
      @(negedge clk);
    end
    host_wr_en = 1'b0;
    cell_ready = 1'b0;
    chk(k == NW, "R6 word count", k, NW);
    chk(req_pending == 2'b00, meddle ? "R9 cmd locked, R8 cleared" : "R8 cleared", req_pending, 0);
    chk(!cell_valid, "R8 valid low", cell_valid, 0);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < NW; i++) exp_buf[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_pending == 2'b00, "R10 req reset", req_pending, 0);
    chk(!cell_valid, "R10 valid reset", cell_valid, 0);
    // R10: untouched payload reads as zeros
    run_cell(2'b01, 1'b0);
    // R1: edges of the window, then random fill
    host_write(BASE, 16'hA5A5);
    host_write(BASE + NW - 1, 16'h5A5A);
    for (int i = 1; i < NW - 1; i++) host_write(BASE + i, WORD_W'($urandom));
    run_cell(2'b10, 1'b0);
    // R11: writes just outside the window and elsewhere
    host_write(BASE + NW, 16'hDEAD);
    host_write(BASE - 2, 16'hBEEF);
    host_write(8'h00, 16'h0003);
    chk(req_pending == 2'b00, "R11 req untouched", req_pending, 0);
    run_cell(2'b01, 1'b0);
    // R4: both bits set behaves as upstream and clears both
    run_cell(2'b11, 1'b0);
    // R9: writes during the cell are dropped
    run_cell(2'b10, 1'b1);
    run_cell(2'b01, 1'b1);
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < NW; i++) host_write(BASE + i, WORD_W'($urandom));
      run_cell(2'($urandom_range(1, 3)), 1'b1);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule